// File: doc/BRIEF.md
# Overcurrent Hiccup and Soft-Start Sequencer

This block runs the fault handling and start-up order for one channel of a voltage-mode buck controller. It works on switching cycles. A one-clock strobe marks the start of each cycle. On every strobe the block samples the overcurrent and negative-overcurrent comparator flags. From these samples it drives three things: the mode of the PWM output stage, a request to discharge the soft-start ramp, and a hold on the bottom switch with a short recurring refresh window.

Sequence of operation:
- When the channel is enabled, the block waits for the soft-start ramp to pass its enable level, with no overcurrent and no prebias present.
- It then drives a fixed number of nonsynchronous cycles, and after those it runs fully synchronous.
- Persistent overcurrent moves the block into a long hiccup wait. During the wait the output stage is tri-stated and the soft-start is held in reset.
- After the wait it starts again through the same nonsynchronous phase.

Pulling the run input low from any state returns the block to idle.

Top module: `hic_ctrl`

## Requirements
- R1: While reset is active, and one clock after any edge where `run_en` is low, `pwm_mode` is 2'b00, `ss_reset` is 1, and `bot_inhibit` and `bot_refresh` are 0.
- R2: One clock after `run_en` rises from idle, `ss_reset` is 0 and `pwm_mode` stays 2'b00. Switching starts only on a `cyc_start` strobe that sees `ss_ready`=1, `oc_flag`=0 and `prebias_flag`=0. A strobe that misses any of these leaves `pwm_mode` at 2'b00.
- R3: The PWM mode encoding is 2'b00 tri-state, 2'b01 nonsynchronous and 2'b10 synchronous; 2'b11 never appears. One clock after a qualifying start strobe the mode is 2'b01. The mode moves to 2'b10 one clock after the NSYNC_CYC-th strobe seen in the nonsynchronous state, and not before.
- R4: While switching (mode 01 or 10), a strobe that brings the count of overcurrent strobes to OC_TRIP declares a fault. One clock later `pwm_mode` is 2'b00 and `ss_reset` is 1.
- R5: A run of fewer than OC_GAP consecutive clean strobes leaves the overcurrent count unchanged. OC_GAP consecutive clean strobes clear it to zero.
- R6: After a fault, `ss_reset` stays 1 and `pwm_mode` stays 2'b00 for exactly HICCUP_CYC strobes. One clock after the last of these, `ss_reset` is 0. The next start follows R2 and R3, beginning with the nonsynchronous phase.
- R7: In synchronous mode, a strobe with `noc_flag`=1 raises `bot_inhibit` one clock later. A strobe with `noc_flag`=0 drops it one clock later. `bot_inhibit` is never high outside mode 2'b10.
- R8: On every REFRESH_PERIOD-th consecutive strobe with `noc_flag`=1, `bot_refresh` goes high for REFRESH_WIDTH clocks starting one clock after that strobe. `bot_inhibit` is low while `bot_refresh` is high.
- R9: Dropping `run_en` clears the overcurrent, nonsynchronous, hiccup and refresh counters. After a restart, a full OC_TRIP overcurrent strobes are again needed for a fault, and a hiccup wait that was in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Channel enable |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| oc_flag | input | 1 | Overcurrent comparator result for the current cycle |
| noc_flag | input | 1 | Negative-overcurrent comparator result for the current cycle |
| prebias_flag | input | 1 | Output is prebiased; blocks the start of switching |
| ss_ready | input | 1 | Soft-start ramp is past its enable level |
| pwm_mode | output | 2 | 00 tri-state, 01 nonsynchronous, 10 synchronous |
| ss_reset | output | 1 | Request to discharge and hold the soft-start ramp |
| bot_inhibit | output | 1 | Hold the bottom switch off |
| bot_refresh | output | 1 | Short bottom-switch on window for driver refresh |

## Verification
The bench builds the block with OC_TRIP=6, OC_GAP=3, HICCUP_CYC=10, NSYNC_CYC=7, REFRESH_PERIOD=4 and REFRESH_WIDTH=2. With these values every counter boundary can be reached in a few dozen strobes. That includes the fault one strobe after the threshold, gap runs one short of and exactly at the clearing length, and the full hiccup wait counted strobe by strobe. It also includes three complete refresh periods checked at every strobe. NSYNC_CYC keeps its real value, so each strobe of the nonsynchronous phase is checked.

// File: rtl/hic_pkg.sv
package hic_pkg;

  typedef enum logic [1:0] {
    PWM_TRI   = 2'b00,
    PWM_NSYNC = 2'b01,
    PWM_SYNC  = 2'b10
  } pwm_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_NSYNC,
    ST_SYNC,
    ST_HICCUP
  } hic_state_e;

endpackage

// File: rtl/hic_step_counter.sv
// Counts qualified steps; 'done' pulses combinationally on the LIMIT-th step.
module hic_step_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic done
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = step && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr || done) cnt <= '0;
    else if (step)        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hic_oc_filter.sv
// Persistent-overcurrent detector: OC strobes accumulate, a run of clean strobes clears.
module hic_oc_filter #(
  parameter int OC_TRIP = 128,
  parameter int OC_GAP  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic oc,
  output logic fault
);
  logic oc_step, clean_step, gap_done;

  assign oc_step    = step && oc;
  assign clean_step = step && !oc;

  // run of clean strobes; restarts on any overcurrent strobe
  hic_step_counter #(.LIMIT(OC_GAP)) u_gap (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr || oc_step),
    .step (clean_step),
    .done (gap_done)
  );

  // overcurrent tally; survives short gaps
  hic_step_counter #(.LIMIT(OC_TRIP)) u_trip (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr || gap_done),
    .step (oc_step),
    .done (fault)
  );
endmodule

// File: rtl/hic_noc_refresh.sv
// Bottom-switch hold under negative overcurrent with a periodic refresh window.
module hic_noc_refresh #(
  parameter int REFRESH_PERIOD = 8,
  parameter int REFRESH_WIDTH  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic noc,
  output logic inhibit,
  output logic refresh
);
  localparam int RW = $clog2(REFRESH_WIDTH + 1);
  localparam logic [RW-1:0] RLOAD = RW'(REFRESH_WIDTH);

  logic          period_done;
  logic          noc_seen;
  logic [RW-1:0] win_cnt;

  hic_step_counter #(.LIMIT(REFRESH_PERIOD)) u_period (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr || (step && !noc)),
    .step (step && noc),
    .done (period_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      noc_seen <= 1'b0;
      win_cnt  <= '0;
    end else if (clr) begin
      noc_seen <= 1'b0;
      win_cnt  <= '0;
    end else begin
      if (step) noc_seen <= noc;
      if (period_done)        win_cnt <= RLOAD;
      else if (win_cnt != '0) win_cnt <= win_cnt - 1'b1;
    end
  end

  assign refresh = (win_cnt != '0);
  assign inhibit = noc_seen && !refresh;
endmodule

// File: rtl/hic_ctrl.sv
module hic_ctrl
  import hic_pkg::*;
#(
  parameter int OC_TRIP        = 128,
  parameter int OC_GAP         = 7,
  parameter int HICCUP_CYC     = 32768,
  parameter int NSYNC_CYC      = 7,
  parameter int REFRESH_PERIOD = 8,
  parameter int REFRESH_WIDTH  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       cyc_start,
  input  logic       oc_flag,
  input  logic       noc_flag,
  input  logic       prebias_flag,
  input  logic       ss_ready,
  output logic [1:0] pwm_mode,
  output logic       ss_reset,
  output logic       bot_inhibit,
  output logic       bot_refresh
);
  hic_state_e state, state_nxt;
  logic switching, start_ok;
  logic oc_fault, nsync_done, hiccup_done;
  logic inh_raw, ref_raw;

  assign switching = (state == ST_NSYNC) || (state == ST_SYNC);
  assign start_ok  = cyc_start && ss_ready && !oc_flag && !prebias_flag;

  hic_oc_filter #(.OC_TRIP(OC_TRIP), .OC_GAP(OC_GAP)) u_oc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!run_en || !switching),
    .step (cyc_start && switching),
    .oc   (oc_flag),
    .fault(oc_fault)
  );

  hic_step_counter #(.LIMIT(NSYNC_CYC)) u_nsync (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!run_en || state != ST_NSYNC),
    .step (cyc_start && state == ST_NSYNC),
    .done (nsync_done)
  );

  hic_step_counter #(.LIMIT(HICCUP_CYC)) u_hiccup (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!run_en || state != ST_HICCUP),
    .step (cyc_start && state == ST_HICCUP),
    .done (hiccup_done)
  );

  hic_noc_refresh #(.REFRESH_PERIOD(REFRESH_PERIOD), .REFRESH_WIDTH(REFRESH_WIDTH)) u_noc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!run_en || state != ST_SYNC),
    .step   (cyc_start && state == ST_SYNC),
    .noc    (noc_flag),
    .inhibit(inh_raw),
    .refresh(ref_raw)
  );

  always_comb begin
    state_nxt = state;
    if (!run_en) begin
      state_nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:   state_nxt = ST_ARM;
        ST_ARM:    if (start_ok) state_nxt = ST_NSYNC;
        ST_NSYNC: begin
          if (oc_fault)        state_nxt = ST_HICCUP;
          else if (nsync_done) state_nxt = ST_SYNC;
        end
        ST_SYNC:   if (oc_fault) state_nxt = ST_HICCUP;
        ST_HICCUP: if (hiccup_done) state_nxt = ST_ARM;
        default:   state_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  always_comb begin
    unique case (state)
      ST_NSYNC: pwm_mode = PWM_NSYNC;
      ST_SYNC:  pwm_mode = PWM_SYNC;
      default:  pwm_mode = PWM_TRI;
    endcase
  end

  assign ss_reset    = (state == ST_IDLE) || (state == ST_HICCUP);
  assign bot_inhibit = inh_raw && (state == ST_SYNC);
  assign bot_refresh = ref_raw && (state == ST_SYNC);
endmodule

// File: rtl/hic_ctrl_chk.sv
module hic_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_en,
  input logic       cyc_start,
  input logic       oc_flag,
  input logic       prebias_flag,
  input logic       ss_ready,
  input logic [1:0] pwm_mode,
  input logic       ss_reset,
  input logic       bot_inhibit,
  input logic       bot_refresh
);
  assert_idle_on_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (pwm_mode == 2'b00 && ss_reset && !bot_inhibit && !bot_refresh));

  assert_start_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwm_mode) == 2'b00 && pwm_mode != 2'b00) |->
      (pwm_mode == 2'b01 &&
       $past(run_en && cyc_start && ss_ready && !oc_flag && !prebias_flag)));

  assert_mode_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_mode != 2'b11);

  assert_sync_after_nsync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwm_mode) != 2'b10 && pwm_mode == 2'b10) |-> $past(pwm_mode) == 2'b01);

  assert_ssreset_tristate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_reset |-> pwm_mode == 2'b00);

  assert_inhibit_sync_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bot_inhibit |-> pwm_mode == 2'b10);

  assert_refresh_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bot_refresh |-> !bot_inhibit);
endmodule

bind hic_ctrl hic_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_en      (run_en),
  .cyc_start   (cyc_start),
  .oc_flag     (oc_flag),
  .prebias_flag(prebias_flag),
  .ss_ready    (ss_ready),
  .pwm_mode    (pwm_mode),
  .ss_reset    (ss_reset),
  .bot_inhibit (bot_inhibit),
  .bot_refresh (bot_refresh)
);

// File: tb/hic_ctrl_tb.sv
module hic_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TRIP  = 6;
  localparam int GAP   = 3;
  localparam int HIC   = 10;
  localparam int NSY   = 7;
  localparam int RPER  = 4;
  localparam int RWID  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, cyc_start = 1'b0, oc_flag = 1'b0, noc_flag = 1'b0;
  logic prebias_flag = 1'b0, ss_ready = 1'b0;
  logic [1:0] pwm_mode;
  logic ss_reset, bot_inhibit, bot_refresh;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hic_ctrl #(
    .OC_TRIP(TRIP), .OC_GAP(GAP), .HICCUP_CYC(HIC), .NSYNC_CYC(NSY),
    .REFRESH_PERIOD(RPER), .REFRESH_WIDTH(RWID)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cyc_start(cyc_start),
    .oc_flag(oc_flag), .noc_flag(noc_flag), .prebias_flag(prebias_flag),
    .ss_ready(ss_ready), .pwm_mode(pwm_mode), .ss_reset(ss_reset),
    .bot_inhibit(bot_inhibit), .bot_refresh(bot_refresh)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one strobe; returns at the negedge after the capturing edge
  task automatic strobe(input logic oc, input logic noc);
    @(negedge clk);
    cyc_start = 1'b1; oc_flag = oc; noc_flag = noc;
    @(negedge clk);
    cyc_start = 1'b0; oc_flag = 1'b0; noc_flag = 1'b0;
  endtask

  task automatic bring_to_sync(input string req);
    strobe(1'b0, 1'b0);
    check({req, " start nonsync"}, pwm_mode, 1);
    for (int k = 1; k <= NSY; k++) begin
      strobe(1'b0, 1'b0);
      check({req, " nonsync count"}, pwm_mode, (k < NSY) ? 1 : 2);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle(3);
    // R1: reset state
    check("R1 mode in reset", pwm_mode, 0);
    check("R1 ss_reset in reset", ss_reset, 1);
    rst_n = 1'b1;
    idle(2);
    check("R1 idle mode", pwm_mode, 0);
    check("R1 idle ss_reset", ss_reset, 1);
    check("R1 idle inhibit", bot_inhibit, 0);

    // R2: arming and start qualification
    run_en = 1'b1;
    idle(1);
    check("R2 armed ss_reset", ss_reset, 0);
    check("R2 armed mode", pwm_mode, 0);
    strobe(1'b0, 1'b0);
    check("R2 no ss_ready", pwm_mode, 0);
    ss_ready = 1'b1; prebias_flag = 1'b1;
    strobe(1'b0, 1'b0);
    check("R2 prebias blocks", pwm_mode, 0);
    prebias_flag = 1'b0;
    strobe(1'b1, 1'b0);
    check("R2 overcurrent blocks", pwm_mode, 0);

    // R3: nonsync phase length
    bring_to_sync("R3");

    // R7: negative overcurrent inhibit
    strobe(1'b0, 1'b1);
    check("R7 inhibit on", bot_inhibit, 1);
    check("R7 no refresh yet", bot_refresh, 0);
    strobe(1'b0, 1'b0);
    check("R7 inhibit off", bot_inhibit, 0);

    // R8: refresh every RPER consecutive noc strobes
    for (int k = 1; k <= 3 * RPER; k++) begin
      strobe(1'b0, 1'b1);
      check("R8 refresh pattern", bot_refresh, (k % RPER == 0) ? 1 : 0);
      check("R8 inhibit pattern", bot_inhibit, (k % RPER == 0) ? 0 : 1);
      if (k % RPER == 0) begin
        idle(RWID - 1);
        check("R8 refresh width held", bot_refresh, 1);
        idle(1);
        check("R8 refresh width end", bot_refresh, 0);
        check("R8 inhibit restored", bot_inhibit, 1);
      end
    end
    strobe(1'b0, 1'b0);
    check("R7 inhibit cleared", bot_inhibit, 0);

    // R5 then R4: short gap keeps the count
    for (int k = 0; k < TRIP - 1; k++) strobe(1'b1, 1'b0);
    for (int k = 0; k < GAP - 1; k++) strobe(1'b0, 1'b0);
    check("R5 short gap no fault", pwm_mode, 2);
    strobe(1'b1, 1'b0);
    check("R4 fault mode", pwm_mode, 0);
    check("R4 fault ss_reset", ss_reset, 1);

    // R6: hiccup wait
    for (int k = 1; k <= HIC; k++) begin
      strobe(1'b0, 1'b0);
      check("R6 hiccup ss_reset", ss_reset, (k < HIC) ? 1 : 0);
      check("R6 hiccup mode", pwm_mode, 0);
    end
    bring_to_sync("R6 restart");

    // R5: a full gap clears the count
    for (int k = 0; k < TRIP - 1; k++) strobe(1'b1, 1'b0);
    for (int k = 0; k < GAP; k++) strobe(1'b0, 1'b0);
    for (int k = 0; k < TRIP - 1; k++) strobe(1'b1, 1'b0);
    check("R5 full gap cleared", pwm_mode, 2);
    strobe(1'b1, 1'b0);
    check("R4 fault after clear", pwm_mode, 0);

    // R9: stop during hiccup abandons it
    strobe(1'b0, 1'b0);
    @(negedge clk); run_en = 1'b0;
    idle(1);
    check("R9 stop mode", pwm_mode, 0);
    check("R9 stop ss_reset", ss_reset, 1);
    run_en = 1'b1;
    idle(1);
    check("R9 hiccup abandoned", ss_reset, 0);
    bring_to_sync("R9");

    // R9: stop clears the overcurrent tally
    for (int k = 0; k < TRIP - 1; k++) strobe(1'b1, 1'b0);
    @(negedge clk); run_en = 1'b0;
    idle(1);
    check("R1 stop from sync", pwm_mode, 0);
    run_en = 1'b1;
    idle(1);
    bring_to_sync("R9 second");
    for (int k = 0; k < TRIP - 1; k++) strobe(1'b1, 1'b0);
    check("R9 tally cleared", pwm_mode, 2);
    strobe(1'b1, 1'b0);
    check("R9 fault after full tally", pwm_mode, 0);

    done = 1'b1;
    finish_run();
  end
endmodule